// File: doc/BRIEF.md
# Memory Block-Copy Sequencer

This block moves bytes from one memory area to another, one byte per step. Each step reads the byte at the source pointer and writes it to the address in the destination pointer. It then moves both pointers one place and takes one off a byte counter. A two-bit mode picks the direction: the pointers either rise or fall. The mode also picks whether the engine stops after one byte or keeps going until the counter is exhausted. The host CPU core decodes the copy instruction. It then loads the three pointer and counter values and a flag byte, and pulses start. When the engine finishes, the core reads back the updated values and flags.

The time each step takes is modelled with a cycle counter, one clock per machine state. A step after which copying continues lasts 21 clocks. A step that ends the operation lasts 16 clocks. The completion pulse appears only after that time has passed. In repeat modes an interrupt-pending input is sampled once per byte, when the byte's write completes. If a request is pending and bytes remain, the engine stops with the pointers and counter already updated and raises a suspend pulse. The core can then take the interrupt and start the engine again from the read-back values.

Top module: `blkxfer_engine`

## Requirements
- R1: Each step asserts `mem_rd_o` with `mem_addr_o` equal to the source pointer in its first cycle. Read data is expected on `mem_rdata_i` one cycle after a read. In the third cycle of the step, the engine asserts `mem_wr_o` with `mem_addr_o` equal to the destination pointer and `mem_wdata_o` equal to that byte.
- R2: When `mode_i[0]` is 0 (ascending), every step adds one to the source and destination pointers and subtracts one from the counter. All arithmetic is modulo 2^16.
- R3: When `mode_i[0]` is 1 (descending), every step subtracts one from the source pointer, the destination pointer and the counter.
- R4: When `mode_i[1]` is 0 (single mode), exactly one byte is copied and then `done_o` pulses for one cycle.
- R5: When `mode_i[1]` is 1 (repeat mode), steps continue while the counter is non-zero after the decrement. `done_o` pulses once the counter reaches zero.
- R6: The start is accepted at clock edge 0. With that count, `done_o` or `susp_o` is high in the cycle after edge T. T is the sum of the step costs: 21 for each step that is followed by another step, and 16 for the step that ends the operation.
- R7: The flag byte loaded from `flags_i` at start is updated after every step. Bit 4 and bit 1 are cleared. Bits 7, 6, 5, 3 and 0 keep their loaded values.
- R8: After every step, flag bit 2 is 1 if the counter is non-zero and 0 if it is zero. In repeat mode this makes it 0 at completion.
- R9: In repeat mode, `int_pend_i` is sampled in the write cycle of each step. If it is set and the counter is non-zero after the decrement, the engine stops after that step's 16 clocks. It pulses `susp_o` instead of `done_o` and leaves the updated values on its outputs. A fresh start loaded from those values completes the remaining bytes.
- R10: `int_pend_i` has no effect in single mode, or on the step that brings the counter to zero. Those operations end with `done_o`.
- R11: A counter of zero at start wraps to 0xFFFF after the first step, so the copy keeps going and flag bit 2 is set.
- R12: `start_i` is ignored while `busy_o` is high.
- R13: After reset, `busy_o`, `done_o`, `susp_o`, `mem_rd_o` and `mem_wr_o` are 0, and all pointer, counter and flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| mode_i | input | 2 | Bit 0: descending; bit 1: repeat |
| src_ld_i | input | AW | Source pointer value loaded at start |
| dst_ld_i | input | AW | Destination pointer value loaded at start |
| cnt_ld_i | input | AW | Byte counter value loaded at start |
| flags_i | input | 8 | Flag byte loaded at start |
| int_pend_i | input | 1 | Interrupt pending, sampled in the write cycle |
| mem_addr_o | output | AW | Memory address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, one cycle after the read |
| src_o | output | AW | Current source pointer |
| dst_o | output | AW | Current destination pointer |
| cnt_o | output | AW | Current byte counter |
| flags_o | output | 8 | Current flag byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse at completion |
| susp_o | output | 1 | One-cycle pulse when stopped for an interrupt |

## Verification
The hardest case to reach from the ports is a suspension. It needs a repeat copy, bytes still left after the decrement, and `int_pend_i` high in exactly the write cycle. The stimulus reaches it by holding `int_pend_i` high for the whole of a repeat start, so the first write sees it. The bench then checks that the partly updated values appear on the outputs, restarts the engine from those outputs, and checks both the remaining bytes and the restart timing. A zero counter under a held interrupt brings out the wrap to 0xFFFF after one step, with no need to run 65536 bytes.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_READ  = 3'd1,
      ST_LATCH = 3'd2,
      ST_WRITE = 3'd3,
      ST_WAIT  = 3'd4
   } xfer_state_t;

   localparam int FLAG_W     = 8;
   localparam int FLAG_HALF  = 4;
   localparam int FLAG_PAR   = 2;
   localparam int FLAG_SUB   = 1;
   localparam int MODE_DOWN  = 0;
   localparam int MODE_RPT   = 1;

endpackage

// File: rtl/blkxfer_ptr_unit.sv
module blkxfer_ptr_unit #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         step_i,
   input  logic         down_i,
   output logic [W-1:0] val_o,
   output logic [W-1:0] next_o
);

   assign next_o = down_i ? (val_o - 1'b1) : (val_o + 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_o <= '0;
      end else if (load_i) begin
         val_o <= load_val_i;
      end else if (step_i) begin
         val_o <= next_o;
      end
   end

endmodule

// File: rtl/blkxfer_step_timer.sv
module blkxfer_step_timer #(
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart_i,
   input  logic          run_i,
   output logic [CW-1:0] count_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_o <= '0;
      end else if (restart_i) begin
         count_o <= {{(CW-1){1'b0}}, 1'b1};
      end else if (run_i) begin
         count_o <= count_o + 1'b1;
      end
   end

endmodule

// File: rtl/blkxfer_engine.sv
module blkxfer_engine
   import blkxfer_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 8,
   parameter int COST_LAST = 16,
   parameter int COST_MORE = 21
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [1:0]    mode_i,
   input  logic [AW-1:0] src_ld_i,
   input  logic [AW-1:0] dst_ld_i,
   input  logic [AW-1:0] cnt_ld_i,
   input  logic [7:0]    flags_i,
   input  logic          int_pend_i,
   output logic [AW-1:0] mem_addr_o,
   output logic          mem_rd_o,
   output logic          mem_wr_o,
   output logic [DW-1:0] mem_wdata_o,
   input  logic [DW-1:0] mem_rdata_i,
   output logic [AW-1:0] src_o,
   output logic [AW-1:0] dst_o,
   output logic [AW-1:0] cnt_o,
   output logic [7:0]    flags_o,
   output logic          busy_o,
   output logic          done_o,
   output logic          susp_o
);

   localparam int            CW     = $clog2(COST_MORE + 1);
   localparam int            NREG   = 3;
   localparam int            IDX_CNT = 2;
   localparam logic [CW-1:0] LAST_C = CW'(COST_LAST);
   localparam logic [CW-1:0] MORE_C = CW'(COST_MORE);

   // elaboration-time parameter checks
   if (COST_LAST < 4) begin : g_chk_last
      $error("COST_LAST must cover read, latch, write and one wait cycle");
   end
   if (COST_MORE < COST_LAST) begin : g_chk_more
      $error("COST_MORE must not be below COST_LAST");
   end
   if (AW < 2 || DW < 1) begin : g_chk_width
      $error("address or data width out of range");
   end

   xfer_state_t   state_q, state_d;
   logic [1:0]    mode_q;
   logic [DW-1:0] byte_q;
   logic [7:0]    flags_q;
   logic          stop_q, susp_pend_q;
   logic          done_q, susp_q;
   logic [CW-1:0] tcount;

   logic          accept, step, at_end, enter_read;
   logic [AW-1:0] ld_val [NREG];
   logic [AW-1:0] cur    [NREG];
   logic [AW-1:0] nxt    [NREG];

   assign accept     = (state_q == ST_IDLE) && start_i;
   assign step       = (state_q == ST_WRITE);
   assign at_end     = (state_q == ST_WAIT) && (tcount == (stop_q ? LAST_C : MORE_C));
   assign enter_read = accept || (at_end && !stop_q);

   assign ld_val[0]       = src_ld_i;
   assign ld_val[1]       = dst_ld_i;
   assign ld_val[IDX_CNT] = cnt_ld_i;

   // source pointer, destination pointer and counter share one update unit type
   for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam bit IS_CNT = (g == IDX_CNT);
      logic dir_down;
      if (IS_CNT) begin : g_cnt_dir
         assign dir_down = 1'b1;
      end else begin : g_ptr_dir
         assign dir_down = mode_q[MODE_DOWN];
      end
      blkxfer_ptr_unit #(.W(AW)) i_reg (
         .clk        (clk),
         .rst_n      (rst_n),
         .load_i     (accept),
         .load_val_i (ld_val[g]),
         .step_i     (step),
         .down_i     (dir_down),
         .val_o      (cur[g]),
         .next_o     (nxt[g])
      );
   end

   blkxfer_step_timer #(.CW(CW)) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (enter_read),
      .run_i     (busy_o),
      .count_o   (tcount)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (start_i) state_d = ST_READ;
         ST_READ:  state_d = ST_LATCH;
         ST_LATCH: state_d = ST_WRITE;
         ST_WRITE: state_d = ST_WAIT;
         ST_WAIT:  if (at_end) state_d = stop_q ? ST_IDLE : ST_READ;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         mode_q      <= '0;
         byte_q      <= '0;
         flags_q     <= '0;
         stop_q      <= 1'b0;
         susp_pend_q <= 1'b0;
         done_q      <= 1'b0;
         susp_q      <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= at_end && stop_q && !susp_pend_q;
         susp_q  <= at_end && stop_q && susp_pend_q;
         if (accept) begin
            mode_q      <= mode_i;
            flags_q     <= flags_i;
            stop_q      <= 1'b0;
            susp_pend_q <= 1'b0;
         end
         if (state_q == ST_LATCH) begin
            byte_q <= mem_rdata_i;
         end
         if (step) begin
            flags_q[FLAG_HALF] <= 1'b0;
            flags_q[FLAG_SUB]  <= 1'b0;
            flags_q[FLAG_PAR]  <= (nxt[IDX_CNT] != '0);
            stop_q      <= !mode_q[MODE_RPT] || (nxt[IDX_CNT] == '0) || int_pend_i;
            susp_pend_q <= mode_q[MODE_RPT] && (nxt[IDX_CNT] != '0) && int_pend_i;
         end
      end
   end

   assign mem_rd_o    = (state_q == ST_READ);
   assign mem_wr_o    = (state_q == ST_WRITE);
   assign mem_addr_o  = mem_wr_o ? cur[1] : cur[0];
   assign mem_wdata_o = byte_q;

   assign src_o   = cur[0];
   assign dst_o   = cur[1];
   assign cnt_o   = cur[IDX_CNT];
   assign flags_o = flags_q;
   assign busy_o  = (state_q != ST_IDLE);
   assign done_o  = done_q;
   assign susp_o  = susp_q;

endmodule

// File: rtl/blkxfer_engine_chk.sv
module blkxfer_engine_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_rd_o,
   input logic          mem_wr_o,
   input logic [AW-1:0] mem_addr_o,
   input logic [AW-1:0] src_o,
   input logic [AW-1:0] dst_o,
   input logic [AW-1:0] cnt_o,
   input logic [7:0]    flags_o,
   input logic          done_o,
   input logic          susp_o,
   input logic [1:0]    mode_q
);

   // R1: a write is always preceded by a read two cycles earlier
   assert_write_after_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_o |-> $past(mem_rd_o, 2));

   // R1: the write goes to the destination pointer
   assert_write_to_dst_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_o |-> (mem_addr_o == dst_o));

   assert_ascend_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mem_wr_o) && !mode_q[0]) |->
         (src_o == $past(src_o) + 1'b1) && (dst_o == $past(dst_o) + 1'b1));

   assert_descend_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mem_wr_o) && mode_q[0]) |->
         (src_o == $past(src_o) - 1'b1) && (dst_o == $past(dst_o) - 1'b1));

   assert_cnt_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mem_wr_o) |-> (cnt_o == $past(cnt_o) - 1'b1));

   assert_repeat_ends_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && mode_q[1]) |-> (cnt_o == '0));

   assert_flags_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mem_wr_o) |-> (!flags_o[4] && !flags_o[1]));

   assert_flags_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mem_wr_o) |-> (flags_o[7:5] == $past(flags_o[7:5])) &&
                          (flags_o[3] == $past(flags_o[3])) &&
                          (flags_o[0] == $past(flags_o[0])));

   assert_parity_tracks_cnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mem_wr_o) |-> (flags_o[2] == (cnt_o != '0)));

   assert_susp_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      susp_o |-> ((cnt_o != '0) && mode_q[1]));

   assert_end_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && susp_o));

endmodule

bind blkxfer_engine blkxfer_engine_chk #(.AW(AW)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_rd_o   (mem_rd_o),
   .mem_wr_o   (mem_wr_o),
   .mem_addr_o (mem_addr_o),
   .src_o      (src_o),
   .dst_o      (dst_o),
   .cnt_o      (cnt_o),
   .flags_o    (flags_o),
   .done_o     (done_o),
   .susp_o     (susp_o),
   .mode_q     (mode_q)
);

// File: tb/test_blkxfer_engine.sv
`timescale 1ns/1ps
module test_blkxfer_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  mode_i = '0;
   logic [15:0] src_ld_i = '0, dst_ld_i = '0, cnt_ld_i = '0;
   logic [7:0]  flags_i = '0;
   logic        int_pend_i = 1'b0;
   logic [15:0] mem_addr_o;
   logic        mem_rd_o, mem_wr_o;
   logic [7:0]  mem_wdata_o;
   logic [7:0]  mem_rdata_i = '0;
   logic [15:0] src_o, dst_o, cnt_o;
   logic [7:0]  flags_o;
   logic        busy_o, done_o, susp_o;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   blkxfer_engine i_blkxfer_engine (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .src_ld_i(src_ld_i), .dst_ld_i(dst_ld_i), .cnt_ld_i(cnt_ld_i),
      .flags_i(flags_i), .int_pend_i(int_pend_i),
      .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
      .src_o(src_o), .dst_o(dst_o), .cnt_o(cnt_o), .flags_o(flags_o),
      .busy_o(busy_o), .done_o(done_o), .susp_o(susp_o)
   );

   function automatic logic [7:0] pat(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   function automatic logic [7:0] exp_flags(input logic [7:0] f, input logic [15:0] c);
      return (f & 8'hE9) | ((c != 16'h0) ? 8'h04 : 8'h00);
   endfunction

   // memory model: one-cycle read latency, filled with a pattern during reset
   logic [7:0] mem [0:65535];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int a = 0; a < 65536; a++) mem[a] <= pat(16'(a));
      end else begin
         if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
         if (mem_wr_o) mem[mem_addr_o] <= mem_wdata_o;
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic run_xfer(input logic [1:0] md, input logic [15:0] s, input logic [15:0] d,
                           input logic [15:0] c, input logic [7:0] f, input logic ip,
                           output int cyc, output logic got_done, output logic got_susp);
      @(negedge clk);
      mode_i = md; src_ld_i = s; dst_ld_i = d; cnt_ld_i = c; flags_i = f;
      int_pend_i = ip; start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      cyc = 0;
      got_done = 1'b0; got_susp = 1'b0;
      while (1) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
         if (done_o || susp_o) begin
            got_done = done_o; got_susp = susp_o;
            break;
         end
         if (cyc > 3000) begin
            chk("watchdog run", 32'(cyc), 32'd0);
            break;
         end
      end
      int_pend_i = 1'b0;
   endtask

   task automatic t_reset;
      chk("R13 busy", 32'(busy_o), 0);
      chk("R13 done/susp", {done_o, susp_o}, 0);
      chk("R13 mem strobes", {mem_rd_o, mem_wr_o}, 0);
      chk("R13 src/dst", {src_o, dst_o}, 0);
      chk("R13 cnt/flags", {cnt_o, flags_o}, 0);
   endtask

   task automatic t_single_up;
      int cyc; logic dn, sp;
      run_xfer(2'b00, 16'h1000, 16'h2000, 16'd3, 8'hD9, 1'b0, cyc, dn, sp);
      chk("R1 byte copied", mem[16'h2000], pat(16'h1000));
      chk("R2 src", src_o, 16'h1001);
      chk("R2 dst", dst_o, 16'h2001);
      chk("R2 cnt", cnt_o, 16'd2);
      chk("R4 done single", {dn, sp}, 2'b10);
      chk("R4 next byte untouched", mem[16'h2001], pat(16'h2001));
      chk("R6 single cost", 32'(cyc), 16);
      chk("R7 flags", flags_o, exp_flags(8'hD9, 16'd2));
      chk("R8 pv set", 32'(flags_o[2]), 1);
   endtask

   task automatic t_single_down;
      int cyc; logic dn, sp;
      run_xfer(2'b01, 16'h3000, 16'h4000, 16'd1, 8'h16, 1'b0, cyc, dn, sp);
      chk("R3 byte copied", mem[16'h4000], pat(16'h3000));
      chk("R3 regs", {src_o, dst_o}, {16'h2FFF, 16'h3FFF});
      chk("R3 cnt", cnt_o, 16'd0);
      chk("R8 pv clear", flags_o, 8'h00);
      chk("R6 cost", 32'(cyc), 16);
   endtask

   task automatic t_repeat_up;
      int cyc; logic dn, sp;
      run_xfer(2'b10, 16'h1100, 16'h5000, 16'd4, 8'h41, 1'b0, cyc, dn, sp);
      for (int i = 0; i < 4; i++)
         chk("R5 repeat up data", mem[16'h5000 + 16'(i)], pat(16'h1100 + 16'(i)));
      chk("R5 regs", {src_o, dst_o}, {16'h1104, 16'h5004});
      chk("R5 cnt zero", cnt_o, 16'd0);
      chk("R5 done", {dn, sp}, 2'b10);
      chk("R6 repeat cost", 32'(cyc), 21 * 3 + 16);
      chk("R8 pv at end", flags_o, 8'h41);
   endtask

   task automatic t_repeat_down;
      int cyc; logic dn, sp;
      run_xfer(2'b11, 16'h6002, 16'h7002, 16'd3, 8'hFF, 1'b0, cyc, dn, sp);
      for (int i = 0; i < 3; i++)
         chk("R3 repeat down data", mem[16'h7000 + 16'(i)], pat(16'h6000 + 16'(i)));
      chk("R3 regs", {src_o, dst_o}, {16'h5FFF, 16'h6FFF});
      chk("R6 repeat down cost", 32'(cyc), 21 * 2 + 16);
      chk("R7 flags", flags_o, exp_flags(8'hFF, 16'd0));
   endtask

   task automatic t_suspend;
      int cyc; logic dn, sp;
      logic [15:0] s, d, c;
      run_xfer(2'b10, 16'h1200, 16'h7100, 16'd5, 8'h80, 1'b1, cyc, dn, sp);
      chk("R9 suspended", {dn, sp}, 2'b01);
      chk("R9 regs updated", {src_o, dst_o, cnt_o}, {16'h1201, 16'h7101, 16'd4});
      chk("R9 pv", flags_o, 8'h84);
      chk("R9 one byte only", mem[16'h7101], pat(16'h7101));
      chk("R6 suspend cost", 32'(cyc), 16);
      s = src_o; d = dst_o; c = cnt_o;
      run_xfer(2'b10, s, d, c, flags_o, 1'b0, cyc, dn, sp);
      chk("R9 resumed done", {dn, sp}, 2'b10);
      for (int i = 0; i < 5; i++)
         chk("R9 resumed data", mem[16'h7100 + 16'(i)], pat(16'h1200 + 16'(i)));
      chk("R9 resume cost", 32'(cyc), 21 * 3 + 16);
   endtask

   task automatic t_int_ignored;
      int cyc; logic dn, sp;
      run_xfer(2'b11, 16'h1600, 16'h7500, 16'd1, 8'h00, 1'b1, cyc, dn, sp);
      chk("R10 last step done", {dn, sp}, 2'b10);
      chk("R10 last step cnt", cnt_o, 16'd0);
      run_xfer(2'b00, 16'h1700, 16'h7600, 16'd5, 8'h00, 1'b1, cyc, dn, sp);
      chk("R10 single done", {dn, sp}, 2'b10);
      chk("R10 single regs", {src_o, cnt_o}, {16'h1701, 16'd4});
   endtask

   task automatic t_wrap;
      int cyc; logic dn, sp;
      run_xfer(2'b10, 16'h1400, 16'h7300, 16'd0, 8'h00, 1'b1, cyc, dn, sp);
      chk("R11 repeat continues", {dn, sp}, 2'b01);
      chk("R11 cnt wraps", cnt_o, 16'hFFFF);
      chk("R11 pv", flags_o, 8'h04);
      chk("R11 data", mem[16'h7300], pat(16'h1400));
      run_xfer(2'b01, 16'h1500, 16'h7400, 16'd0, 8'h00, 1'b0, cyc, dn, sp);
      chk("R11 single wrap", {src_o, cnt_o}, {16'h14FF, 16'hFFFF});
   endtask

   task automatic t_busy_start;
      int cyc = 0;
      @(negedge clk);
      mode_i = 2'b10; src_ld_i = 16'h1800; dst_ld_i = 16'h7700; cnt_ld_i = 16'd2;
      flags_i = 8'h00; start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      while (1) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
         if (cyc == 5 || cyc == 22) begin
            mode_i = 2'b01; src_ld_i = 16'h1900; dst_ld_i = 16'h7800;
            cnt_ld_i = 16'd9; start_i = 1'b1;
         end else begin
            start_i = 1'b0;
         end
         if (done_o || susp_o || cyc > 3000) break;
      end
      start_i = 1'b0;
      chk("R12 cost unchanged", 32'(cyc), 21 + 16);
      chk("R12 regs of first op", {src_o, dst_o, cnt_o}, {16'h1802, 16'h7702, 16'd0});
      chk("R12 data", mem[16'h7701], pat(16'h1801));
      chk("R12 no stray write", mem[16'h7800], pat(16'h7800));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_single_up();
      t_single_down();
      t_repeat_up();
      t_repeat_down();
      t_suspend();
      t_int_ignored();
      t_wrap();
      t_busy_start();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule